// File: doc/BRIEF.md
# Bridge Driver Fault Status Aggregator

This block gathers the digital fault indications around an H-bridge output stage and turns them into sticky status flags, one summary bit, an active-low fault pin and a shared output-disable line. The inputs are supply over-voltage, supply under-voltage, over-current on each of the four power switches, over-temperature, open load seen while driving, and a pulse marking a bad serial transfer. A power-on flag is raised by reset. Every flag stays set until a clear-fault pulse arrives.

Over-current and open-load indications are qualified by counting consecutive cycles. The over-current window is picked by a 2-bit code and converted to cycles from a clock-frequency parameter. The open-load window is a short or a long count. Each fault class (supply, over-current, over-temperature, open load) has its own reaction bit. In latched mode the class keeps the bridge disabled until a clear arrives while the fault is gone. In automatic mode the class releases the bridge a fixed number of cycles after the fault goes away, and its flag remains for software to see. A single reaction bit covers both supply faults.

Top module: `fa_fault_agg`

## Requirements
- R1: `flg_sum` is 1 exactly when any of the communication, power-on, over-voltage, under-voltage, over-current or over-temperature flags is set; the open-load flag never sets it. `flg_ocp_any` is the OR of the four `flg_ocp` bits.
- R2: After reset, `flg_por` is 1, all other flags are 0, `drv_off` is 0 and `fault_n` is 0.
- R3: `flg_ocp` bit order is [3] high-side OUT1, [2] low-side OUT1, [1] high-side OUT2, [0] low-side OUT2. A bit sets only after its raw input has been high for N consecutive cycles, where N is CLK_MHZ*6, CLK_MHZ*3, CLK_MHZ*3/2 or CLK_MHZ/5 for `ocp_flt_sel` 00, 01, 10, 11. A low cycle restarts the count.
- R4: `flg_ol` sets after 16 consecutive high cycles of `raw_ol` when `ol_long` is 0, or after 1024 when it is 1, and only while `ol_en` is 1.
- R5: With a class reaction bit at 0, `drv_off` stays 1 after that fault until a `clr_fault` pulse is sampled while the raw fault is low. A clear that arrives while the fault is present has no effect.
- R6: With a class reaction bit at 1, `drv_off` remains 1 while the fault is present. It returns to 0 exactly RETRY_CYC cycles after the first cycle the fault is sampled low. The class flag stays set.
- R7: A `clr_fault` pulse clears every flag, including `flg_por`. If a fault is detected in the same cycle as the clear, that fault's flag stays set.
- R8: `ovp_sel` = 11 disables the over-voltage input, so neither its flag nor `drv_off` responds to it. `retry_sup` selects the reaction for both over-voltage and under-voltage.
- R9: `fault_n` is 0 exactly when `flg_sum` or `flg_ol` is 1.
- R10: A `comm_err` pulse sets `flg_comm` and asserts the summary bit, but does not set `drv_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_ovp | input | 1 | Supply over-voltage indication |
| raw_uvp | input | 1 | Supply under-voltage indication |
| raw_ocp | input | 4 | Per-switch over-current indications |
| raw_otp | input | 1 | Over-temperature indication |
| raw_ol | input | 1 | Open load while driving |
| comm_err | input | 1 | One-cycle pulse marking a bad transfer |
| ol_en | input | 1 | Enables open-load qualification |
| ol_long | input | 1 | Open-load window: 0 short, 1 long |
| ovp_sel | input | 2 | Over-voltage select; 11 disables the check |
| ocp_flt_sel | input | 2 | Over-current filter window code |
| retry_sup | input | 1 | Supply reaction: 1 automatic, 0 latched |
| retry_ocp | input | 1 | Over-current reaction |
| retry_otp | input | 1 | Over-temperature reaction |
| retry_ol | input | 1 | Open-load reaction |
| clr_fault | input | 1 | Clear-all pulse |
| flg_comm | output | 1 | Communication error flag |
| flg_por | output | 1 | Power-on flag |
| flg_sum | output | 1 | Summary fault bit |
| flg_ovp | output | 1 | Over-voltage flag |
| flg_uvp | output | 1 | Under-voltage flag |
| flg_ocp | output | 4 | Per-switch over-current flags |
| flg_ocp_any | output | 1 | OR of over-current flags |
| flg_otp | output | 1 | Over-temperature flag |
| flg_ol | output | 1 | Open-load flag |
| fault_n | output | 1 | Active-low fault pin |
| drv_off | output | 1 | Bridge output disable |

## Verification
Two events can land in the same clock cycle: a clear-fault pulse and the detection of a new fault. The bench drives `clr_fault` and a raw over-temperature input high on the same edge. It expects the flag to end up set, because detection takes priority over the clear. A second case drives a clear while a latched over-current is still present. There the bench expects both the flag and `drv_off` to hold, and both to release only after a clear that arrives once the input has dropped.

// File: rtl/fa_pkg.sv
`timescale 1ns/1ps
package fa_pkg;
  typedef enum logic [1:0] {
    CLS_RUN  = 2'd0,
    CLS_HOLD = 2'd1,
    CLS_WAIT = 2'd2
  } cls_state_e;

  localparam int unsigned N_SW    = 4;
  localparam int unsigned N_CLS   = 4;
  localparam int unsigned CLS_SUP = 0;
  localparam int unsigned CLS_OCP = 1;
  localparam int unsigned CLS_OTP = 2;
  localparam int unsigned CLS_OL  = 3;
endpackage

// File: rtl/fa_rst_sync.sv
`timescale 1ns/1ps
module fa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/fa_filter.sv
`timescale 1ns/1ps
module fa_filter #(
  parameter int unsigned CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          raw,
  input  logic [CW-1:0] limit,
  output logic          qual
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_lim;

  assign at_lim = (cnt_q >= limit);

  // consecutive-high counter, saturating at the window limit
  always_comb begin
    cnt_d = cnt_q;
    if (!en || !raw)  cnt_d = '0;
    else if (!at_lim) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign qual = en & raw & at_lim;
endmodule

// File: rtl/fa_class_ctl.sv
`timescale 1ns/1ps
module fa_class_ctl
  import fa_pkg::*;
#(
  parameter int unsigned RETRY_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qual,
  input  logic present,
  input  logic retry_en,
  input  logic clr,
  output logic off
);
  localparam int unsigned RW = $clog2(RETRY_CYC + 1);

  cls_state_e    st_q, st_d;
  logic [RW-1:0] rc_q, rc_d;

  always_comb begin
    st_d = st_q;
    rc_d = rc_q;
    unique case (st_q)
      CLS_RUN: begin
        if (qual) st_d = CLS_HOLD;
      end
      CLS_HOLD: begin
        if (!present) begin
          if (retry_en) begin
            st_d = CLS_WAIT;
            rc_d = '0;
          end else if (clr) begin
            st_d = CLS_RUN;
          end
        end
      end
      CLS_WAIT: begin
        if (present || !retry_en)            st_d = CLS_HOLD;
        else if (rc_q == RW'(RETRY_CYC - 1)) st_d = CLS_RUN;
        else                                 rc_d = rc_q + 1'b1;
      end
      default: st_d = CLS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= CLS_RUN;
      rc_q <= '0;
    end else begin
      st_q <= st_d;
      rc_q <= rc_d;
    end
  end

  assign off = (st_q != CLS_RUN);
endmodule

// File: rtl/fa_fault_agg.sv
`timescale 1ns/1ps
module fa_fault_agg
  import fa_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 50,
  parameter int unsigned OL_SHORT  = 16,
  parameter int unsigned OL_LONG   = 1024,
  parameter int unsigned RETRY_CYC = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_ovp,
  input  logic       raw_uvp,
  input  logic [3:0] raw_ocp,
  input  logic       raw_otp,
  input  logic       raw_ol,
  input  logic       comm_err,
  input  logic       ol_en,
  input  logic       ol_long,
  input  logic [1:0] ovp_sel,
  input  logic [1:0] ocp_flt_sel,
  input  logic       retry_sup,
  input  logic       retry_ocp,
  input  logic       retry_otp,
  input  logic       retry_ol,
  input  logic       clr_fault,
  output logic       flg_comm,
  output logic       flg_por,
  output logic       flg_sum,
  output logic       flg_ovp,
  output logic       flg_uvp,
  output logic [3:0] flg_ocp,
  output logic       flg_ocp_any,
  output logic       flg_otp,
  output logic       flg_ol,
  output logic       fault_n,
  output logic       drv_off
);
  // over-current windows in cycles
  localparam int unsigned LIM_6US  = CLK_MHZ * 6;
  localparam int unsigned LIM_3US  = CLK_MHZ * 3;
  localparam int unsigned LIM_1US5 = (CLK_MHZ * 3) / 2;
  localparam int unsigned LIM_MIN  = (CLK_MHZ / 5) > 0 ? (CLK_MHZ / 5) : 1;
  localparam int unsigned OCW      = $clog2(LIM_6US + 1);
  localparam int unsigned OLW      = $clog2(OL_LONG + 1);

  logic rst_s_n;

  fa_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  // ---------------- qualification ----------------
  logic [OCW-1:0]  ocp_lim;
  logic [OLW-1:0]  ol_lim;
  logic [N_SW-1:0] ocp_det;
  logic            ol_det;
  logic            ovp_det;

  always_comb begin
    unique case (ocp_flt_sel)
      2'b00:   ocp_lim = OCW'(LIM_6US);
      2'b01:   ocp_lim = OCW'(LIM_3US);
      2'b10:   ocp_lim = OCW'(LIM_1US5);
      default: ocp_lim = OCW'(LIM_MIN);
    endcase
  end

  assign ol_lim  = ol_long ? OLW'(OL_LONG) : OLW'(OL_SHORT);
  assign ovp_det = raw_ovp & (ovp_sel != 2'b11);

  for (genvar i = 0; i < N_SW; i++) begin : g_ocp
    fa_filter #(.CW(OCW)) u_flt (
      .clk   (clk),
      .rst_n (rst_s_n),
      .en    (1'b1),
      .raw   (raw_ocp[i]),
      .limit (ocp_lim),
      .qual  (ocp_det[i])
    );
  end

  fa_filter #(.CW(OLW)) u_ol_flt (
    .clk   (clk),
    .rst_n (rst_s_n),
    .en    (ol_en),
    .raw   (raw_ol),
    .limit (ol_lim),
    .qual  (ol_det)
  );

  // ---------------- sticky flags ----------------
  logic            comm_q, por_q, ovp_q, uvp_q, otp_q, ol_q;
  logic            comm_d, por_d, ovp_d, uvp_d, otp_d, ol_d;
  logic [N_SW-1:0] ocp_q, ocp_d;

  // detection wins over a clear in the same cycle
  always_comb begin
    comm_d = (comm_q & ~clr_fault) | comm_err;
    por_d  =  por_q  & ~clr_fault;
    ovp_d  = (ovp_q  & ~clr_fault) | ovp_det;
    uvp_d  = (uvp_q  & ~clr_fault) | raw_uvp;
    otp_d  = (otp_q  & ~clr_fault) | raw_otp;
    ol_d   = (ol_q   & ~clr_fault) | ol_det;
    ocp_d  = (ocp_q  & ~{N_SW{clr_fault}}) | ocp_det;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      comm_q <= 1'b0;
      por_q  <= 1'b1;
      ovp_q  <= 1'b0;
      uvp_q  <= 1'b0;
      otp_q  <= 1'b0;
      ol_q   <= 1'b0;
      ocp_q  <= '0;
    end else begin
      comm_q <= comm_d;
      por_q  <= por_d;
      ovp_q  <= ovp_d;
      uvp_q  <= uvp_d;
      otp_q  <= otp_d;
      ol_q   <= ol_d;
      ocp_q  <= ocp_d;
    end
  end

  // ---------------- per-class reaction ----------------
  logic [N_CLS-1:0] cls_qual, cls_pres, cls_retry, cls_off;

  always_comb begin
    cls_qual[CLS_SUP]  = ovp_det | raw_uvp;
    cls_pres[CLS_SUP]  = ovp_det | raw_uvp;
    cls_retry[CLS_SUP] = retry_sup;
    cls_qual[CLS_OCP]  = |ocp_det;
    cls_pres[CLS_OCP]  = |raw_ocp;
    cls_retry[CLS_OCP] = retry_ocp;
    cls_qual[CLS_OTP]  = raw_otp;
    cls_pres[CLS_OTP]  = raw_otp;
    cls_retry[CLS_OTP] = retry_otp;
    cls_qual[CLS_OL]   = ol_det;
    cls_pres[CLS_OL]   = raw_ol & ol_en;
    cls_retry[CLS_OL]  = retry_ol;
  end

  for (genvar c = 0; c < N_CLS; c++) begin : g_cls
    fa_class_ctl #(.RETRY_CYC(RETRY_CYC)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_s_n),
      .qual     (cls_qual[c]),
      .present  (cls_pres[c]),
      .retry_en (cls_retry[c]),
      .clr      (clr_fault),
      .off      (cls_off[c])
    );
  end

  // ---------------- outputs ----------------
  assign flg_comm    = comm_q;
  assign flg_por     = por_q;
  assign flg_ovp     = ovp_q;
  assign flg_uvp     = uvp_q;
  assign flg_otp     = otp_q;
  assign flg_ol      = ol_q;
  assign flg_ocp     = ocp_q;
  assign flg_ocp_any = |ocp_q;
  assign flg_sum     = comm_q | por_q | ovp_q | uvp_q | (|ocp_q) | otp_q;
  assign fault_n     = ~(flg_sum | ol_q);
  assign drv_off     = |cls_off;
endmodule

// File: rtl/fa_fault_agg_chk.sv
`timescale 1ns/1ps
module fa_fault_agg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr_fault,
  input logic       raw_otp,
  input logic [3:0] raw_ocp,
  input logic [3:0] flg_ocp,
  input logic       flg_otp,
  input logic [1:0] ovp_sel,
  input logic       flg_ovp,
  input logic       ol_en,
  input logic       flg_ol,
  input logic       fault_n,
  input logic       drv_off,
  input logic       retry_sup,
  input logic       retry_ocp,
  input logic       retry_otp,
  input logic       retry_ol
);
  // R3: an over-current flag only rises after its raw input was high
  assert_ocp_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_ocp[0]) |-> $past(raw_ocp[0]));

  // R4: no open-load flag appears while qualification is disabled
  assert_ol_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ol_en && !flg_ol) |=> !flg_ol);

  // R5: latched reaction holds the bridge off until a clear
  assert_latched_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_off && !clr_fault && !retry_sup && !retry_ocp && !retry_otp && !retry_ol)
      |=> drv_off);

  // R7: a clear with no temperature fault empties its flag
  assert_clear_otp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fault && !raw_otp) |=> !flg_otp);

  // R8: a disabled over-voltage check never raises its flag
  assert_ovp_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_sel == 2'b11 && !flg_ovp) |=> !flg_ovp);

  // R9: an open-load flag always pulls the fault pin low
  assert_ol_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flg_ol |-> !fault_n);
endmodule

bind fa_fault_agg fa_fault_agg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .clr_fault (clr_fault),
  .raw_otp   (raw_otp),
  .raw_ocp   (raw_ocp),
  .flg_ocp   (flg_ocp),
  .flg_otp   (flg_otp),
  .ovp_sel   (ovp_sel),
  .flg_ovp   (flg_ovp),
  .ol_en     (ol_en),
  .flg_ol    (flg_ol),
  .fault_n   (fault_n),
  .drv_off   (drv_off),
  .retry_sup (retry_sup),
  .retry_ocp (retry_ocp),
  .retry_otp (retry_otp),
  .retry_ol  (retry_ol)
);

// File: tb/tb_fa_fault_agg.sv
`timescale 1ns/1ps
module tb_fa_fault_agg;
  localparam int RETRY = 100;
  localparam int LIM_MIN = 10;
  localparam int LIM_1US5 = 75;

  logic clk = 1'b0;
  logic rst_n;
  logic raw_ovp, raw_uvp, raw_otp, raw_ol, comm_err;
  logic [3:0] raw_ocp;
  logic ol_en, ol_long;
  logic [1:0] ovp_sel, ocp_flt_sel;
  logic retry_sup, retry_ocp, retry_otp, retry_ol, clr_fault;
  logic flg_comm, flg_por, flg_sum, flg_ovp, flg_uvp, flg_ocp_any, flg_otp, flg_ol;
  logic fault_n, drv_off;
  logic [3:0] flg_ocp;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fa_fault_agg #(.CLK_MHZ(50), .OL_SHORT(16), .OL_LONG(1024), .RETRY_CYC(RETRY)) dut (
    .clk(clk), .rst_n(rst_n), .raw_ovp(raw_ovp), .raw_uvp(raw_uvp), .raw_ocp(raw_ocp),
    .raw_otp(raw_otp), .raw_ol(raw_ol), .comm_err(comm_err), .ol_en(ol_en),
    .ol_long(ol_long), .ovp_sel(ovp_sel), .ocp_flt_sel(ocp_flt_sel),
    .retry_sup(retry_sup), .retry_ocp(retry_ocp), .retry_otp(retry_otp),
    .retry_ol(retry_ol), .clr_fault(clr_fault), .flg_comm(flg_comm), .flg_por(flg_por),
    .flg_sum(flg_sum), .flg_ovp(flg_ovp), .flg_uvp(flg_uvp), .flg_ocp(flg_ocp),
    .flg_ocp_any(flg_ocp_any), .flg_otp(flg_otp), .flg_ol(flg_ol),
    .fault_n(fault_n), .drv_off(drv_off)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_pulse();
    clr_fault = 1'b1;
    tick(1);
    clr_fault = 1'b0;
  endtask

  task automatic t_reset();
    chk("R2 por flag", flg_por, 1);
    chk("R2 other flags", {flg_comm, flg_ovp, flg_uvp, flg_ocp, flg_otp, flg_ol}, 0);
    chk("R2 drv_off", drv_off, 0);
    chk("R2 fault_n", fault_n, 0);
    chk("R1 sum from por", flg_sum, 1);
    clear_pulse();
    chk("R7 por cleared", flg_por, 0);
    chk("R9 fault_n released", fault_n, 1);
  endtask

  task automatic t_ocp();
    ocp_flt_sel = 2'b11;
    raw_ocp = 4'b0001;
    tick(LIM_MIN - 1);
    raw_ocp = 4'b0000;
    tick(1);
    raw_ocp = 4'b0001;
    tick(LIM_MIN - 1);
    chk("R3 glitch restarts count", flg_ocp, 0);
    tick(1);
    chk("R3 not before window end", flg_ocp, 0);
    tick(1);
    chk("R3 low-side OUT2 flag", flg_ocp, 4'b0001);
    chk("R1 ocp any", flg_ocp_any, 1);
    chk("R5 latched off", drv_off, 1);
    clear_pulse();
    chk("R5 clear while present ignored flag", flg_ocp, 4'b0001);
    chk("R5 clear while present ignored off", drv_off, 1);
    raw_ocp = 4'b0000;
    tick(5);
    chk("R5 stays off without clear", drv_off, 1);
    clear_pulse();
    chk("R5 released by clear", drv_off, 0);
    chk("R7 ocp cleared", flg_ocp, 0);
    ocp_flt_sel = 2'b10;
    raw_ocp = 4'b1000;
    tick(LIM_1US5);
    chk("R3 1.5us window not yet", flg_ocp, 0);
    tick(1);
    chk("R3 high-side OUT1 flag", flg_ocp, 4'b1000);
    raw_ocp = 4'b0000;
    tick(1);
    clear_pulse();
    chk("R5 second release", drv_off, 0);
  endtask

  task automatic t_ol();
    raw_ol = 1'b1;
    ol_en = 1'b0;
    tick(40);
    chk("R4 disabled no flag", flg_ol, 0);
    chk("R4 disabled fault_n", fault_n, 1);
    ol_en = 1'b1;
    ol_long = 1'b0;
    tick(16);
    chk("R4 short not yet", flg_ol, 0);
    tick(1);
    chk("R4 short flag", flg_ol, 1);
    chk("R1 sum excludes open load", flg_sum, 0);
    chk("R9 fault_n from open load", fault_n, 0);
    raw_ol = 1'b0;
    tick(1);
    clear_pulse();
    chk("R7 ol cleared", flg_ol, 0);
    ol_long = 1'b1;
    raw_ol = 1'b1;
    tick(1024);
    chk("R4 long not yet", flg_ol, 0);
    tick(1);
    chk("R4 long flag", flg_ol, 1);
    raw_ol = 1'b0;
    ol_en = 1'b0;
    tick(1);
    clear_pulse();
    chk("R5 ol released", drv_off, 0);
  endtask

  task automatic t_retry_otp();
    retry_otp = 1'b1;
    raw_otp = 1'b1;
    tick(1);
    chk("R6 otp off", drv_off, 1);
    tick(20);
    chk("R6 off while present", drv_off, 1);
    raw_otp = 1'b0;
    tick(RETRY);
    chk("R6 still off at delay end", drv_off, 1);
    tick(1);
    chk("R6 released after delay", drv_off, 0);
    chk("R6 flag kept", flg_otp, 1);
    clear_pulse();
    retry_otp = 1'b0;
  endtask

  task automatic t_supply();
    retry_sup = 1'b1;
    raw_uvp = 1'b1;
    tick(1);
    chk("R8 uvp flag", flg_uvp, 1);
    chk("R8 uvp off", drv_off, 1);
    raw_uvp = 1'b0;
    tick(RETRY);
    chk("R8 uvp retry holding", drv_off, 1);
    tick(1);
    chk("R8 uvp retry release", drv_off, 0);
    clear_pulse();
    retry_sup = 1'b0;
    raw_ovp = 1'b1;
    tick(1);
    chk("R8 ovp flag", flg_ovp, 1);
    raw_ovp = 1'b0;
    tick(RETRY + 5);
    chk("R8 ovp latched", drv_off, 1);
    clear_pulse();
    chk("R8 ovp released by clear", drv_off, 0);
    ovp_sel = 2'b11;
    raw_ovp = 1'b1;
    tick(10);
    chk("R8 disabled ovp flag", flg_ovp, 0);
    chk("R8 disabled ovp off", drv_off, 0);
    raw_ovp = 1'b0;
    ovp_sel = 2'b00;
    tick(1);
  endtask

  task automatic t_clr_race();
    raw_otp = 1'b1;
    clr_fault = 1'b1;
    tick(1);
    clr_fault = 1'b0;
    chk("R7 detection beats clear", flg_otp, 1);
    raw_otp = 1'b0;
    tick(1);
    clear_pulse();
    chk("R7 otp cleared", flg_otp, 0);
    chk("R5 otp released", drv_off, 0);
  endtask

  task automatic t_comm();
    comm_err = 1'b1;
    tick(1);
    comm_err = 1'b0;
    chk("R10 comm flag", flg_comm, 1);
    chk("R10 summary", flg_sum, 1);
    chk("R10 no disable", drv_off, 0);
    chk("R9 fault_n from comm", fault_n, 0);
    clear_pulse();
    chk("R7 comm cleared", flg_comm, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    raw_ovp = 0; raw_uvp = 0; raw_otp = 0; raw_ol = 0; comm_err = 0; raw_ocp = '0;
    ol_en = 0; ol_long = 0; ovp_sel = 2'b00; ocp_flt_sel = 2'b00;
    retry_sup = 0; retry_ocp = 0; retry_otp = 0; retry_ol = 0; clr_fault = 0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_ocp();
    t_ol();
    t_retry_otp();
    t_supply();
    t_clr_race();
    t_comm();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule